// File: doc/BRIEF.md
# Event-Driven PWM Channel

This block produces one pulse-width-modulated output bit. An internal counter runs either as a down counter that reloads, or as an up/down counter that moves between zero and a programmed load value. Each cycle the counter value is compared with zero, the load value and two compare values, A and B. Up to six events can result: zero, load, A while rising, A while falling, B while rising and B while falling.

A 12-bit action word gives each event a 2-bit action: keep, invert, force low or force high. When several events fall in the same cycle, only the highest-priority one acts on the output. Software programs the action word, the load value and the two compare values through a small register port. The mode input chooses the counting style. The enable input starts the counter or freezes it.

Top module: `pwm_event_gen`

## Requirements
- R1: After a synchronous active-low reset, `pwm_out` is 0 and all four registers read 0.
- R2: Register address 0 holds the action word. Bits 11:0 read back as written. Bits 31:12 always read 0, whatever was written.
- R3: Addresses 1, 2 and 3 hold the load value, compare A and compare B. Each stores the low `CNT_W` bits of the write data and reads back zero-extended.
- R4: When `updown` is 0, the counter is a down counter:
  - After reset it starts at 0.
  - On each enabled cycle it steps to the load value if it is at 0, and otherwise decrements by one.
  - The period is load+1 enabled cycles.
  - Only the zero, load, A-falling and B-falling events occur.
- R5: When `updown` is 1, the counter runs 0, 1, … load, load-1, … 0, 1, …, one step per enabled cycle. A compare match is a rising event while counting up and a falling event while counting down.
- R6: Action word fields, two bits each:
  - bits 1:0 = zero
  - bits 3:2 = load
  - bits 5:4 = A rising
  - bits 7:6 = A falling
  - bits 9:8 = B rising
  - bits 11:10 = B falling

  The action codes are 00 = keep, 01 = invert, 10 = low, 11 = high. The output register takes the new value on the clock edge that ends the cycle in which the event's counter value is present.
- R7: A zero or load event in the same cycle as a compare event applies only its own action. The compare action is dropped.
- R8: A compare A event in the same cycle as a compare B event applies only the A action.
- R9: In down-counting mode the rising-compare actions never affect the output.
- R10: When the load value is 0, the zero and load events coincide and only the zero action is applied.
- R11: While `run_en` is 0, the counter and `pwm_out` hold their values and no event acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 action word, 1 load, 2 compare A, 3 compare B |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| updown | input | 1 | 0 = down counting, 1 = up/down counting |
| run_en | input | 1 | Counter enable |
| pwm_out | output | 1 | PWM output |

## Verification
A wrong counter value or direction bit shows up at `pwm_out` at the next event whose action changes the output. The bench therefore compares the output every cycle against a model while sweeping every load and compare combination for small load values, both modes and several action words. A wrong choice among coinciding events corrupts the output on the first edge where those events meet. An all-invert action word makes every dropped or extra event visible within one period.

// File: rtl/pwm_evt_pkg.sv
// Package: shared constants and types for the event-driven PWM channel.
// Assumes event indices double as priority (lower index wins) and as the
// 2-bit field slot inside the action word.
package pwm_evt_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_FLIP = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } act_e;

    localparam int NUM_EV   = 6;
    localparam int ACT_BITS = 2 * NUM_EV;

    // Event index = priority rank = field slot in the action word
    localparam int EV_ZERO = 0;
    localparam int EV_LOAD = 1;
    localparam int EV_A_UP = 2;
    localparam int EV_A_DN = 3;
    localparam int EV_B_UP = 4;
    localparam int EV_B_DN = 5;

    localparam logic [1:0] ADDR_ACT  = 2'd0;
    localparam logic [1:0] ADDR_LOAD = 2'd1;
    localparam logic [1:0] ADDR_CMPA = 2'd2;
    localparam logic [1:0] ADDR_CMPB = 2'd3;

endpackage

// File: rtl/pwm_cfg_regs.sv
// Module: configuration registers of the PWM channel.
// Holds the 12-bit action word and the load / compare values; read data is
// combinational on the address. Assumes CNT_W <= DATA_W.
module pwm_cfg_regs
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [ACT_BITS-1:0] act_word,
    output logic [CNT_W-1:0]    load_val,
    output logic [CNT_W-1:0]    cmpa_val,
    output logic [CNT_W-1:0]    cmpb_val
);

    localparam int PAD_ACT = DATA_W - ACT_BITS;
    localparam int PAD_CNT = DATA_W - CNT_W;

    // Register writes, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_word <= '0;
            load_val <= '0;
            cmpa_val <= '0;
            cmpb_val <= '0;
        end else if (we) begin
            case (addr)
                ADDR_ACT:  act_word <= wdata[ACT_BITS-1:0];
                ADDR_LOAD: load_val <= wdata[CNT_W-1:0];
                ADDR_CMPA: cmpa_val <= wdata[CNT_W-1:0];
                default:   cmpb_val <= wdata[CNT_W-1:0];
            endcase
        end
    end

    // Read multiplexer with zero padding above stored bits
    always_comb begin
        case (addr)
            ADDR_ACT:  rdata = {{PAD_ACT{1'b0}}, act_word};
            ADDR_LOAD: rdata = {{PAD_CNT{1'b0}}, load_val};
            ADDR_CMPA: rdata = {{PAD_CNT{1'b0}}, cmpa_val};
            default:   rdata = {{PAD_CNT{1'b0}}, cmpb_val};
        endcase
    end

    // R2: low action bits take the written value
    assert_act_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_ACT) |=> act_word == $past(wdata[ACT_BITS-1:0]));

    // R3: load value takes the written value
    assert_load_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_LOAD) |=> load_val == $past(wdata[CNT_W-1:0]));

endmodule

// File: rtl/pwm_counter.sv
// Module: PWM period counter.
// Down mode: 0 -> load -> load-1 ... -> 0. Up/down mode: 0 up to load, then
// back down to 0. Holds while run is low. Assumes mode changes only while
// the counter is at rest or in reset; a count above load in up/down mode
// is walked down.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             updown,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             dir_up
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Count and direction update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            dir_up <= 1'b0;
        end else if (run) begin
            if (!updown) begin
                dir_up <= 1'b0;
                count  <= (count == '0) ? load_val : count - ONE;
            end else if (count == '0) begin
                dir_up <= (load_val != '0);
                count  <= (load_val == '0) ? '0 : ONE;
            end else if (count >= load_val) begin
                dir_up <= 1'b0;
                count  <= count - ONE;
            end else if (dir_up) begin
                count  <= count + ONE;
            end else begin
                count  <= count - ONE;
            end
        end
    end

    // R11: frozen while disabled
    assert_hold_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count));

    // R4: down mode away from zero steps by exactly one
    assert_down_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !updown && count != '0) |=> count == $past(count) - ONE);

    // R5: up/down mode never leaves the range once inside it
    assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && updown && count <= load_val && $stable(load_val)) |=> count <= load_val);

endmodule

// File: rtl/pwm_event_detect.sv
// Module: turns counter state into the six events, one bit each, indexed as
// in pwm_evt_pkg. Rising-compare events require up/down mode and an upward
// direction; everything is gated by run.
module pwm_event_detect
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              updown,
    input  logic              dir_up,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [CNT_W-1:0]  cmpa_val,
    input  logic [CNT_W-1:0]  cmpb_val,
    output logic [NUM_EV-1:0] evt
);

    localparam int NUM_CMP = 2;

    logic [CNT_W-1:0]   cmp_val [NUM_CMP];
    logic [NUM_CMP-1:0] rising;
    logic [NUM_CMP-1:0] falling;
    logic               going_up;

    assign cmp_val[0] = cmpa_val;
    assign cmp_val[1] = cmpb_val;
    assign going_up   = updown && dir_up;

    // One comparator lane per compare register
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        // Match split by direction
        always_comb begin
            rising[k]  = run && going_up  && (count == cmp_val[k]);
            falling[k] = run && !going_up && (count == cmp_val[k]);
        end
    end

    // Event vector assembly
    always_comb begin
        evt          = '0;
        evt[EV_ZERO] = run && (count == '0);
        evt[EV_LOAD] = run && (count == load_val);
        evt[EV_A_UP] = rising[0];
        evt[EV_A_DN] = falling[0];
        evt[EV_B_UP] = rising[1];
        evt[EV_B_DN] = falling[1];
    end

    // R9: no rising compare in down mode
    assert_no_rise_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !updown |-> !(evt[EV_A_UP] || evt[EV_B_UP]));

    // R11: no event while disabled
    assert_quiet_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> evt == '0);

endmodule

// File: rtl/pwm_out_stage.sv
// Module: picks the winning event (lowest index present) and applies its
// 2-bit action to the registered output. Output resets low and holds when
// no event is present.
module pwm_out_stage
    import pwm_evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EV-1:0]   evt,
    input  logic [ACT_BITS-1:0] act_word,
    output logic                pwm_out
);

    logic [NUM_EV-1:0] win;
    act_e              chosen;
    logic              next_out;

    // Priority pick: scan from lowest priority so the lowest index wins
    always_comb begin
        win    = '0;
        chosen = ACT_KEEP;
        for (int i = NUM_EV - 1; i >= 0; i--) begin
            if (evt[i]) begin
                win    = '0;
                win[i] = 1'b1;
                chosen = act_e'(act_word[2*i +: 2]);
            end
        end
    end

    // Action decode
    always_comb begin
        case (chosen)
            ACT_FLIP: next_out = ~pwm_out;
            ACT_LOW:  next_out = 1'b0;
            ACT_HIGH: next_out = 1'b1;
            default:  next_out = pwm_out;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_out <= 1'b0;
        else        pwm_out <= next_out;
    end

    // R7/R8: exactly one winner whenever any event is present
    assert_single_win_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |-> ($onehot0(win) && win != '0));

    // R10: zero wins over load when both present
    assert_zero_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[EV_ZERO] && evt[EV_LOAD]) |-> win[EV_ZERO]);

    // R6: force-high zero action drives output high
    assert_zero_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[EV_ZERO] && act_word[1:0] == 2'b11) |=> pwm_out);

    // R11: no event, no change
    assert_hold_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0) |=> $stable(pwm_out));

endmodule

// File: rtl/pwm_event_gen.sv
// Module: top of the event-driven PWM channel. Connects registers, counter,
// event detection and output stage. Synchronous active-low reset.
module pwm_event_gen
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              updown,
    input  logic              run_en,
    output logic              pwm_out
);

    logic [ACT_BITS-1:0] act_word;
    logic [CNT_W-1:0]    load_val;
    logic [CNT_W-1:0]    cmpa_val;
    logic [CNT_W-1:0]    cmpb_val;
    logic [CNT_W-1:0]    count;
    logic                dir_up;
    logic [NUM_EV-1:0]   evt;

    pwm_cfg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .act_word (act_word),
        .load_val (load_val),
        .cmpa_val (cmpa_val),
        .cmpb_val (cmpb_val)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_en),
        .updown   (updown),
        .load_val (load_val),
        .count    (count),
        .dir_up   (dir_up)
    );

    pwm_event_detect #(.CNT_W(CNT_W)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_en),
        .updown   (updown),
        .dir_up   (dir_up),
        .count    (count),
        .load_val (load_val),
        .cmpa_val (cmpa_val),
        .cmpb_val (cmpb_val),
        .evt      (evt)
    );

    pwm_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .act_word (act_word),
        .pwm_out  (pwm_out)
    );

    // R1: output low in the cycle after reset
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> !pwm_out);

endmodule

// File: tb/pwm_event_gen_test.sv
module pwm_event_gen_test;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              updown = 1'b0;
    logic              run_en = 1'b0;
    logic              pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_cnt, m_load, m_a, m_b, m_act;
    bit m_up, m_out;

    pwm_event_gen #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .updown(updown),
        .run_en(run_en), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock edge of the requirement model (R4..R11)
    task automatic model_edge();
        int pick;
        bit ev [6];
        if (!rst_n) begin
            m_cnt = 0; m_up = 0; m_out = 0;
            m_load = 0; m_a = 0; m_b = 0; m_act = 0;
            return;
        end
        if (run_en) begin
            ev[0] = (m_cnt == 0);
            ev[1] = (m_cnt == m_load);
            ev[2] = updown && m_up && (m_cnt == m_a);
            ev[3] = !(updown && m_up) && (m_cnt == m_a);
            ev[4] = updown && m_up && (m_cnt == m_b);
            ev[5] = !(updown && m_up) && (m_cnt == m_b);
            pick = -1;
            for (int i = 5; i >= 0; i--) if (ev[i]) pick = i;
            if (pick >= 0) begin
                case ((m_act >> (2 * pick)) & 3)
                    1: m_out = !m_out;
                    2: m_out = 0;
                    3: m_out = 1;
                    default: ;
                endcase
            end
            if (!updown) begin
                m_up = 0;
                m_cnt = (m_cnt == 0) ? m_load : m_cnt - 1;
            end else if (m_cnt == 0) begin
                m_up = (m_load != 0);
                m_cnt = (m_load == 0) ? 0 : 1;
            end else if (m_cnt >= m_load) begin
                m_up = 0; m_cnt = m_cnt - 1;
            end else if (m_up) m_cnt = m_cnt + 1;
            else m_cnt = m_cnt - 1;
        end
        if (reg_we) begin
            case (reg_addr)
                2'd0: m_act = int'(reg_wdata[11:0]);
                2'd1: m_load = int'(reg_wdata[CNT_W-1:0]);
                2'd2: m_a = int'(reg_wdata[CNT_W-1:0]);
                default: m_b = int'(reg_wdata[CNT_W-1:0]);
            endcase
        end
    endtask

    task automatic step(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(req, pwm_out, m_out);
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step("R3");
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input longint exp, input string req);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run_en = 1'b0;
        step("R1");
        step("R1");
        rst_n = 1'b1;
    endtask

    task automatic config_run(input bit ud, input int ld, input int a, input int b,
                              input int act, input int cycles, input bit pause);
        do_reset();
        updown = ud;
        wr(2'd0, DATA_W'(act));
        wr(2'd1, DATA_W'(ld));
        wr(2'd2, DATA_W'(a));
        wr(2'd3, DATA_W'(b));
        run_en = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            // R11: a short pause in the middle
            if (pause && c == cycles / 2) begin
                run_en = 1'b0;
                for (int p = 0; p < 3; p++) step("R11");
                run_en = 1'b1;
            end
            step(ud ? "R5" : "R4");
        end
        run_en = 1'b0;
    endtask

    initial begin
        int loads [5] = '{0, 1, 2, 3, 5};
        int acts [4] = '{32'h555, 32'hB2E, 32'h6D9, 32'h8E7};
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1", pwm_out, 0);
        rd(2'd0, 0, "R1"); rd(2'd1, 0, "R1"); rd(2'd2, 0, "R1"); rd(2'd3, 0, "R1");
        // R2: reserved bits read zero
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, 32'h0000_0FFF, "R2");
        wr(2'd0, 32'hABCD_E5A3);
        rd(2'd0, 32'h0000_05A3, "R2");
        // R3: zero-extended readback of count-width registers
        wr(2'd1, 32'hDEAD_1234); rd(2'd1, 32'h1234, "R3");
        wr(2'd2, 32'h0001_FFFF); rd(2'd2, 32'hFFFF, "R3");
        wr(2'd3, 32'h8000_0007); rd(2'd3, 32'h0007, "R3");

        // R6: zero action high in down mode, load=3 -> goes high after first edge
        config_run(1'b0, 3, 9, 9, 32'h3, 2, 1'b0);
        check("R6", pwm_out, 1);
        // R10: load 0, zero=high, load=low -> output high
        config_run(1'b0, 0, 7, 7, 32'h0000_000B, 6, 1'b0);
        check("R10", pwm_out, 1);
        // R9: only rising-compare actions set, down mode -> output stays low
        config_run(1'b0, 4, 2, 3, 32'h0000_0330, 20, 1'b0);
        check("R9", pwm_out, 0);
        // R8: A and B equal, A=high, B=low, up/down mode -> output goes high
        config_run(1'b1, 4, 2, 2, 32'h0000_AAF0, 3, 1'b0);
        check("R8", pwm_out, 1);
        // R7: compare equal to load, load=high, compare=low, down mode
        config_run(1'b0, 4, 4, 4, 32'h0000_A0AC, 2, 1'b0);
        check("R7", pwm_out, 1);

        // Sweep: both modes, small loads, all compare pairs, several action words (R4-R8)
        for (int ud = 0; ud < 2; ud++)
            for (int li = 0; li < 5; li++)
                for (int a = 0; a <= loads[li]; a++)
                    for (int b = 0; b <= loads[li]; b++)
                        for (int k = 0; k < 4; k++)
                            config_run(ud[0], loads[li], a, b, acts[k],
                                       3 * loads[li] + 6, (k == 0));
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule